// File: doc/BRIEF.md
# Transmit DMA Channel Supervisor

This block supervises a set of transmit DMA channels (eight by default) without moving any data itself. For each channel it holds a configuration word with an operating mode and a credit-enable bit. It keeps a saturating credit counter and tracks whether a transfer command is held in the channel's one-deep command buffer. From that state it raises a per-channel DMA request. It also samples a per-channel buffer-empty level.

Software reaches the block over a simple word-addressed register bus. The bus carries a write strobe with address and data, and the read data is a combinational function of the address. Through it software sees the configuration words, the credit counters, a shared status word and a shared error word. The error word latches four kinds of fault: an internal address fault, a host dword-count mismatch, a command that arrives at a channel whose command buffer is still full, and a FIFO-full indication that arrives while the channel still holds credit. Each error bit is cleared by writing 1 to it.

All event inputs are single-cycle strobes, and there is no back-pressure anywhere. A strobe is acted on in the cycle it is high.

Top module: `txdma_chan_monitor`

Register word addresses, for the default of 8 channels:
- Words 0 to 7 hold the configuration of channel 0 to 7.
- Words 8 to 15 hold the credit counters of channels 0 to 7, read only.
- Word 16 is the status word, read only.
- Word 17 is the error word.

## Requirements
- R1: After reset:
  - every configuration word reads 0 and every credit counter reads 0;
  - the status word reads 0xFFFF0000, provided buf_empty is held high;
  - the error word reads 0, dma_req is 0 and chan_idle is all ones.
- R2: Only two fields of a configuration word are stored: bits 31:30 hold the mode (00 off, 01 pause at end of frame, 10 run, 11 treated as off) and bit 3 enables credit use and requests. All other bits read 0.
- R3: With bit 3 set, a credit_ret strobe raises the channel's counter by 1 and a xfer_done strobe lowers it by 1. Both strobes in the same cycle leave it unchanged. With bit 3 clear the counter holds.
- R4: The credit counter saturates at 2^CRED_W-1 (15 by default) and at 0.
- R5: A cmd_arrive strobe fills an empty command buffer only in run mode. In off and pause-at-end-of-frame modes it is ignored. A xfer_done strobe empties the buffer.
- R6: dma_req for a channel is high exactly when its command buffer is full, bit 3 is set, the mode is run or pause at end of frame, and the credit counter is nonzero.
- R7: In the status word, bit 24+c is channel c's registered buffer-empty level and bit 16+c is 1 when channel c's command buffer is empty. All other bits read 0.
- R8: chan_idle[c] is 1 exactly when both status bits of channel c are 1.
- R9: Error bit c (bits 7:0) is set when fifo_full[c] arrives while bit 3 is set and the channel's credit counter is nonzero.
- R10: Error bit 9+c (bits 16:9) is set when cmd_arrive[c] arrives in run mode while the command buffer is already full. The held command stays and the buffer remains full.
- R11: An addr_err strobe sets error bit 31 and a dword_err strobe sets error bit 30.
- R12: Writing 1 to an error bit clears it and writing 0 leaves it. If a bit is set and cleared in the same cycle, it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| credit_ret | input | NUM_CH | Per-channel credit return strobe |
| xfer_done | input | NUM_CH | Per-channel transfer issued/completed strobe |
| cmd_arrive | input | NUM_CH | Per-channel command arrival strobe |
| fifo_full | input | NUM_CH | Per-channel downstream FIFO full indication |
| buf_empty | input | NUM_CH | Per-channel buffer-empty level |
| addr_err | input | 1 | Internal memory address fault strobe |
| dword_err | input | 1 | Host dword-count mismatch strobe |
| dma_req | output | NUM_CH | Per-channel DMA request |
| chan_idle | output | NUM_CH | Per-channel idle indication |

## Verification
Every strobe and every register write takes effect at the next rising edge. Its result can be read on the bus, or seen on dma_req and chan_idle, from that edge on. Nothing in the block takes longer than one edge.

The bench changes its inputs after a falling edge and lets exactly one rising edge pass. It then sets the address and reads the combinational read data half a period later, well clear of the next edge.

Credit errors and overruns are decided on the counter and buffer values held before that edge. A clear and a set of the same error bit in one cycle therefore have a single defined outcome, and the bench checks that outcome.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_DRAIN = 2'b01,
    MODE_RUN   = 2'b10,
    MODE_RSVD  = 2'b11
  } chan_mode_e;

  localparam int DATA_W       = 32;
  localparam int MODE_MSB     = 31;
  localparam int MODE_LSB     = 30;
  localparam int CRED_EN_BIT  = 3;
  localparam int ERR_ADDR_BIT = 31;
  localparam int ERR_DW_BIT   = 30;
  localparam int ERR_OVR_LSB  = 9;
  localparam int ERR_CRED_LSB = 0;
  localparam int STS_EMPTY_LSB = 24;
  localparam int STS_NOPEND_LSB = 16;
endpackage

// File: rtl/txdma_chan.sv
module txdma_chan
  import txdma_pkg::*;
#(
  parameter int CRED_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              credit_ret,
  input  logic              xfer_done,
  input  logic              cmd_arrive,
  input  logic              fifo_full,
  input  logic              buf_empty_in,
  output chan_mode_e        mode,
  output logic              cred_en,
  output logic [CRED_W-1:0] cred,
  output logic              busy,
  output logic              empty_q,
  output logic              req,
  output logic              cred_err,
  output logic              ovr_err
);
  localparam logic [CRED_W-1:0] CRED_MAX = {CRED_W{1'b1}};

  logic accept_cmd;
  logic serving;

  assign accept_cmd = (mode == MODE_RUN);
  assign serving    = (mode == MODE_RUN) || (mode == MODE_DRAIN);
  assign ovr_err    = cmd_arrive && busy && accept_cmd;
  assign cred_err   = fifo_full && cred_en && (cred != '0);
  assign req        = busy && cred_en && serving && (cred != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_OFF;
      cred_en <= 1'b0;
    end else if (cfg_we) begin
      mode    <= chan_mode_e'(cfg_wdata[MODE_MSB:MODE_LSB]);
      cred_en <= cfg_wdata[CRED_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cred <= '0;
    end else if (cred_en) begin
      unique case ({credit_ret, xfer_done})
        2'b10:   if (cred != CRED_MAX) cred <= cred + 1'b1;
        2'b01:   if (cred != '0) cred <= cred - 1'b1;
        default: cred <= cred;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (!busy && cmd_arrive && accept_cmd) begin
      busy <= 1'b1;
    end else if (xfer_done) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) empty_q <= 1'b1;
    else        empty_q <= buf_empty_in;
  end
endmodule

// File: rtl/txdma_err_reg.sv
module txdma_err_reg
  import txdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_vec,
  input  logic [DATA_W-1:0] clr_vec,
  output logic [DATA_W-1:0] err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (err_q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/txdma_regif.sv
module txdma_regif
  import txdma_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CRED_W = 4,
  parameter int ADDR_W = 6
) (
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  input  logic [NUM_CH*2-1:0]      mode_flat,
  input  logic [NUM_CH-1:0]        cred_en_v,
  input  logic [NUM_CH*CRED_W-1:0] cred_flat,
  input  logic [DATA_W-1:0]        status_w,
  input  logic [DATA_W-1:0]        err_w,
  output logic [NUM_CH-1:0]        cfg_we,
  output logic [DATA_W-1:0]        err_clr,
  output logic [DATA_W-1:0]        reg_rdata
);
  localparam int STS_ADDR = 2 * NUM_CH;
  localparam int ERR_ADDR = 2 * NUM_CH + 1;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_we
    assign cfg_we[c] = reg_we && (int'(reg_addr) == c);
  end

  assign err_clr = (reg_we && int'(reg_addr) == ERR_ADDR) ? reg_wdata : '0;

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(reg_addr) == c) begin
        reg_rdata[MODE_MSB:MODE_LSB] = mode_flat[c*2 +: 2];
        reg_rdata[CRED_EN_BIT]       = cred_en_v[c];
      end
      if (int'(reg_addr) == NUM_CH + c) begin
        reg_rdata[CRED_W-1:0] = cred_flat[c*CRED_W +: CRED_W];
      end
    end
    if (int'(reg_addr) == STS_ADDR) reg_rdata = status_w;
    if (int'(reg_addr) == ERR_ADDR) reg_rdata = err_w;
  end
endmodule

// File: rtl/txdma_chan_monitor.sv
module txdma_chan_monitor
  import txdma_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CRED_W = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_CH-1:0] credit_ret,
  input  logic [NUM_CH-1:0] xfer_done,
  input  logic [NUM_CH-1:0] cmd_arrive,
  input  logic [NUM_CH-1:0] fifo_full,
  input  logic [NUM_CH-1:0] buf_empty,
  input  logic              addr_err,
  input  logic              dword_err,
  output logic [NUM_CH-1:0] dma_req,
  output logic [NUM_CH-1:0] chan_idle
);
  logic [NUM_CH-1:0]        cfg_we;
  logic [NUM_CH*2-1:0]      mode_flat;
  logic [NUM_CH-1:0]        cred_en_v;
  logic [NUM_CH*CRED_W-1:0] cred_flat;
  logic [NUM_CH-1:0]        busy_v;
  logic [NUM_CH-1:0]        empty_v;
  logic [NUM_CH-1:0]        cred_err_v;
  logic [NUM_CH-1:0]        ovr_err_v;
  logic [DATA_W-1:0]        status_w;
  logic [DATA_W-1:0]        err_set;
  logic [DATA_W-1:0]        err_clr;
  logic [DATA_W-1:0]        err_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_mode_e m;
    txdma_chan #(.CRED_W(CRED_W)) u_chan (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we[c]),
      .cfg_wdata    (reg_wdata),
      .credit_ret   (credit_ret[c]),
      .xfer_done    (xfer_done[c]),
      .cmd_arrive   (cmd_arrive[c]),
      .fifo_full    (fifo_full[c]),
      .buf_empty_in (buf_empty[c]),
      .mode         (m),
      .cred_en      (cred_en_v[c]),
      .cred         (cred_flat[c*CRED_W +: CRED_W]),
      .busy         (busy_v[c]),
      .empty_q      (empty_v[c]),
      .req          (dma_req[c]),
      .cred_err     (cred_err_v[c]),
      .ovr_err      (ovr_err_v[c])
    );
    assign mode_flat[c*2 +: 2] = m;
  end

  always_comb begin
    status_w = '0;
    status_w[STS_EMPTY_LSB +: NUM_CH]  = empty_v;
    status_w[STS_NOPEND_LSB +: NUM_CH] = ~busy_v;
  end

  assign chan_idle = empty_v & ~busy_v;

  always_comb begin
    err_set = '0;
    err_set[ERR_ADDR_BIT]           = addr_err;
    err_set[ERR_DW_BIT]             = dword_err;
    err_set[ERR_OVR_LSB +: NUM_CH]  = ovr_err_v;
    err_set[ERR_CRED_LSB +: NUM_CH] = cred_err_v;
  end

  txdma_err_reg u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (err_set),
    .clr_vec (err_clr),
    .err_q   (err_q)
  );

  txdma_regif #(.NUM_CH(NUM_CH), .CRED_W(CRED_W), .ADDR_W(ADDR_W)) u_regif (
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mode_flat (mode_flat),
    .cred_en_v (cred_en_v),
    .cred_flat (cred_flat),
    .status_w  (status_w),
    .err_w     (err_q),
    .cfg_we    (cfg_we),
    .err_clr   (err_clr),
    .reg_rdata (reg_rdata)
  );
endmodule

// File: rtl/txdma_chan_monitor_chk.sv
module txdma_chan_monitor_chk #(
  parameter int NUM_CH = 8,
  parameter int CRED_W = 4,
  parameter int ADDR_W = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_we,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic [31:0]              reg_wdata,
  input logic [31:0]              err_q,
  input logic [NUM_CH-1:0]        fifo_full,
  input logic [NUM_CH-1:0]        cmd_arrive,
  input logic [NUM_CH*CRED_W-1:0] cred_flat,
  input logic [NUM_CH-1:0]        cred_en_v,
  input logic [NUM_CH-1:0]        busy_v,
  input logic [NUM_CH*2-1:0]      mode_flat,
  input logic [NUM_CH-1:0]        dma_req
);
  logic [31:0] clr_mask;
  assign clr_mask = (reg_we && int'(reg_addr) == 2*NUM_CH+1) ? reg_wdata : 32'h0;

  // R12: a set error bit only drops when a 1 was written to it
  p_sticky_until_w1c_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(err_q) & ~$past(clr_mask)) & ~err_q) == 32'h0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R9
    p_cred_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full[c] && cred_en_v[c] && cred_flat[c*CRED_W +: CRED_W] != '0) |=> err_q[c]);
    // R10
    p_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_arrive[c] && busy_v[c] && mode_flat[c*2 +: 2] == 2'b10) |=> err_q[9+c]);
    // R6: no request without a held command
    p_req_needs_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req[c] |-> busy_v[c]);
    // R6: no request without credit
    p_req_needs_credit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cred_flat[c*CRED_W +: CRED_W] == '0) |-> !dma_req[c]);
  end
endmodule

bind txdma_chan_monitor txdma_chan_monitor_chk #(
  .NUM_CH(NUM_CH), .CRED_W(CRED_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .err_q      (err_q),
  .fifo_full  (fifo_full),
  .cmd_arrive (cmd_arrive),
  .cred_flat  (cred_flat),
  .cred_en_v  (cred_en_v),
  .busy_v     (busy_v),
  .mode_flat  (mode_flat),
  .dma_req    (dma_req)
);

// File: tb/test_txdma_chan_monitor.sv
module test_txdma_chan_monitor;
  localparam int NUM_CH = 8;
  localparam int CRED_W = 4;
  localparam int ADDR_W = 6;
  localparam int A_STS = 16;
  localparam int A_ERR = 17;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NUM_CH-1:0] credit_ret = '0, xfer_done = '0, cmd_arrive = '0, fifo_full = '0;
  logic [NUM_CH-1:0] buf_empty = '1;
  logic              addr_err = 1'b0, dword_err = 1'b0;
  logic [NUM_CH-1:0] dma_req, chan_idle;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  txdma_chan_monitor #(.NUM_CH(NUM_CH), .CRED_W(CRED_W), .ADDR_W(ADDR_W)) i_txdma_chan_monitor (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .credit_ret(credit_ret),
    .xfer_done(xfer_done), .cmd_arrive(cmd_arrive), .fifo_full(fifo_full),
    .buf_empty(buf_empty), .addr_err(addr_err), .dword_err(dword_err),
    .dma_req(dma_req), .chan_idle(chan_idle)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = ADDR_W'(a);
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic pulse(input int kind, input int ch);
    case (kind)
      0: credit_ret[ch] = 1'b1;
      1: xfer_done[ch]  = 1'b1;
      2: cmd_arrive[ch] = 1'b1;
      default: fifo_full[ch] = 1'b1;
    endcase
    step();
    credit_ret = '0; xfer_done = '0; cmd_arrive = '0; fifo_full = '0;
  endtask

  task automatic t_reset();
    rd_chk("R1 cfg", 0, 32'h0);
    rd_chk("R1 credit", 8, 32'h0);
    rd_chk("R1 status", A_STS, 32'hFFFF0000);
    rd_chk("R1 error", A_ERR, 32'h0);
    check("R1 dma_req", 32'(dma_req), 32'h0);
    check("R1 chan_idle", 32'(chan_idle), 32'hFF);
  endtask

  task automatic t_cfg();
    wr(2, 32'hFFFFFFFF);
    rd_chk("R2 only mode and bit3", 2, 32'hC0000008);
    wr(2, 32'h80000008);
    rd_chk("R2 run+enable", 2, 32'h80000008);
  endtask

  task automatic t_credit();
    for (int i = 0; i < 3; i++) pulse(0, 2);
    rd_chk("R3 increment", 10, 32'd3);
    pulse(1, 2);
    rd_chk("R3 decrement", 10, 32'd2);
    credit_ret[2] = 1'b1; xfer_done[2] = 1'b1; step();
    credit_ret = '0; xfer_done = '0;
    rd_chk("R3 both strobes", 10, 32'd2);
    wr(2, 32'h80000000);
    pulse(0, 2);
    rd_chk("R3 held when disabled", 10, 32'd2);
    wr(2, 32'h80000008);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 20; i++) pulse(0, 2);
    rd_chk("R4 top saturation", 10, 32'd15);
    for (int i = 0; i < 20; i++) pulse(1, 2);
    rd_chk("R4 zero saturation", 10, 32'd0);
  endtask

  task automatic t_modes();
    pulse(2, 2);
    rd_chk("R5 accepted in run", A_STS, 32'hFFFB0000);
    check("R8 idle drops", 32'(chan_idle), 32'hFB);
    check("R6 no req at zero credit", 32'(dma_req), 32'h0);
    pulse(0, 2);
    check("R6 req with credit", 32'(dma_req), 32'h04);
    wr(2, 32'h40000008);
    check("R6 req kept in drain", 32'(dma_req), 32'h04);
    pulse(1, 2);
    rd_chk("R5 done empties", A_STS, 32'hFFFF0000);
    check("R6 req drops", 32'(dma_req), 32'h0);
    pulse(2, 2);
    rd_chk("R5 ignored in drain", A_STS, 32'hFFFF0000);
    wr(2, 32'h00000008);
    pulse(2, 2);
    rd_chk("R5 ignored when off", A_STS, 32'hFFFF0000);
  endtask

  task automatic t_status();
    buf_empty[3] = 1'b0;
    step();
    rd_chk("R7 empty bit", A_STS, 32'hF7FF0000);
    check("R8 idle follows empty", 32'(chan_idle), 32'hF7);
    buf_empty[3] = 1'b1;
    step();
  endtask

  task automatic t_overrun();
    wr(5, 32'h80000008);
    pulse(2, 5);
    pulse(2, 5);
    rd_chk("R10 overrun bit", A_ERR, 32'h00004000);
    rd_chk("R10 buffer still full", A_STS, 32'hFFDF0000);
    pulse(1, 5);
  endtask

  task automatic t_cred_err();
    wr(6, 32'h80000008);
    pulse(3, 6);
    rd_chk("R9 no error at zero credit", A_ERR, 32'h00004000);
    pulse(0, 5);
    pulse(3, 5);
    rd_chk("R9 credit error", A_ERR, 32'h00004020);
  endtask

  task automatic t_misc_err();
    addr_err = 1'b1; step(); addr_err = 1'b0;
    dword_err = 1'b1; step(); dword_err = 1'b0;
    rd_chk("R11 addr and dword bits", A_ERR, 32'hC0004020);
  endtask

  task automatic t_w1c();
    wr(A_ERR, 32'h0);
    rd_chk("R12 zero write no effect", A_ERR, 32'hC0004020);
    wr(A_ERR, 32'h00004000);
    rd_chk("R12 single clear", A_ERR, 32'hC0000020);
    addr_err = 1'b1;
    wr(A_ERR, 32'h80000000);
    addr_err = 1'b0;
    rd_chk("R12 set wins", A_ERR, 32'hC0000020);
    wr(A_ERR, 32'hFFFFFFFF);
    rd_chk("R12 clear all", A_ERR, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_cfg();
    t_credit();
    t_saturate();
    t_modes();
    t_status();
    t_overrun();
    t_cred_err();
    t_misc_err();
    t_w1c();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule